// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs a short program of NAND flash bus steps and drives an 8-bit raw NAND pin interface. A 32-bit program word packs eight 4-bit opcodes. Each opcode issues a command byte, sends address bytes, moves data between the pins and a small internal byte buffer or a 16-bit single-data register, or waits for the ready/busy line before its transfer. This lets one engine produce read, program, erase and status sequences without a fixed state machine for each.

The control inputs (program word, four packed command bytes, block/page/column address, address length, byte count, wait limit) are held steady while a sequence runs. A one-cycle `start` pulse launches the program. On exit the block raises either a completion flag or a wait-timeout flag. The host fills and inspects the buffer through a simple write port and an asynchronous read port.

Top module: `nand_seq`

## Requirements
- R1: After reset and while idle, `busy`, `cmd_done`, `wait_tmo`, `nf_cle`, `nf_ale` and `nf_dq_oe` are 0, and `nf_we_n` and `nf_re_n` are 1.
- R2: Opcodes run from bits [31:28] down to bits [3:0]. If no ending opcode appears, all eight run and `cmd_done` is set. Every pin byte is one clock with its strobe (`nf_we_n` or `nf_re_n`) low, then one clock high. The two strobes are never low together.
- R3: Opcodes 4, 5, 6 and 7 each send one byte with CLE high and ALE low. Opcode 4 sends `cmd_word[31:24]`, 5 sends [23:16], 6 sends [15:8] and 7 sends [7:0].
- R4: Opcode 1 sends the column with ALE high. With `large_page`=1 it sends two bytes, `col_idx[7:0]` then `{5'b0,col_idx[10:8]}`. With `large_page`=0 it sends one byte, `col_idx[7:0]`.
- R5: Opcode 2 sends the row with ALE high, least significant byte first. The row is `{blk_addr,page_idx[5:0]}` for large pages and `{blk_addr,page_idx[4:0]}` for small pages. `row_bytes_sel` 0, 1, 2 and 3 give 2, 3, 4 and 4 bytes. Opcode 3 sends `user_addr` as one ALE byte.
- R6: Opcode 0 or 15 ends the sequence at once and sets `cmd_done`. None of the later opcodes runs.
- R7: Opcode 8 sends `byte_cnt` bytes with CLE and ALE low and `nf_dq_oe` high. Byte i comes from buffer entry i mod `BUF_DEPTH`. A count of 0 sends nothing.
- R8: Opcode 9 sends `single_wdata[7:0]`. When `wide_single`=1 it then also sends `single_wdata[15:8]`.
- R9: Opcode 10 reads `byte_cnt` bytes. Each byte is sampled from `nf_dq_i` at the clock edge where `nf_re_n` rises, and byte i goes into buffer entry i mod `BUF_DEPTH`. The host reads it back on `buf_raddr`/`buf_rdata`. `nf_dq_oe` is 0 whenever `nf_re_n` is low.
- R10: Opcode 11 reads one byte into `single_rdata[7:0]`, plus a second byte into [15:8] when `wide_single`=1. In one-byte mode, [15:8] keeps its value.
- R11: Opcodes 12 and 13 wait until `nf_rdy` is 1 and then send CMD0 or CMD1. Opcode 14 waits and then reads `byte_cnt` bytes into the buffer. No strobe falls while the block waits.
- R12: If `nf_rdy` stays 0 for 2^(`wait_sel`+5) clocks in a wait step, the block sets `wait_tmo`, clears `busy` and runs none of the remaining opcodes.
- R13: `cmd_done` and `wait_tmo` are never both set. A `start` that is accepted clears both flags. `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the program (accepted when idle) |
| instr | input | 32 | Eight packed 4-bit opcodes, top nibble first |
| cmd_word | input | 32 | Four command bytes, CMD0 in the top byte |
| blk_addr | input | 24 | Block address |
| col_idx | input | 11 | Column index |
| page_idx | input | 6 | Page index within the block |
| large_page | input | 1 | 1 selects large-page address layout |
| row_bytes_sel | input | 2 | Row address byte count select |
| user_addr | input | 8 | Byte sent by opcode 3 |
| byte_cnt | input | 12 | Bulk transfer length |
| wide_single | input | 1 | Single-data opcodes move two bytes |
| single_wdata | input | 16 | Data for opcode 9 |
| single_rdata | output | 16 | Data captured by opcode 11 |
| wait_sel | input | 4 | Wait limit exponent |
| buf_we | input | 1 | Host buffer write enable |
| buf_waddr | input | 4 | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write data |
| buf_raddr | input | 4 | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read data |
| busy | output | 1 | Sequence in progress |
| cmd_done | output | 1 | Sequence completed normally |
| wait_tmo | output | 1 | Sequence aborted by wait limit |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_o` |
| nf_dq_i | input | 8 | Data from the flash |
| nf_rdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench uses the default parameters: a 16-entry buffer, a 12-bit count and a 4-bit wait exponent. With 16 entries, an 18-byte bulk write runs past the buffer end, so the modulo wrap of R7 can be checked. Setting the wait exponent to 0 gives a 32-clock limit, short enough that the exact busy length of a timed-out sequence can be counted clock by clock. The fixed 6-bit page index exercises both the large-page and small-page row packing.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_XFER
    } seq_st_e;

    localparam logic [3:0] OP_END  = 4'h0;
    localparam logic [3:0] OP_COL  = 4'h1;
    localparam logic [3:0] OP_ROW  = 4'h2;
    localparam logic [3:0] OP_USR  = 4'h3;
    localparam logic [3:0] OP_CM0  = 4'h4;
    localparam logic [3:0] OP_CM1  = 4'h5;
    localparam logic [3:0] OP_CM2  = 4'h6;
    localparam logic [3:0] OP_CM3  = 4'h7;
    localparam logic [3:0] OP_WBUF = 4'h8;
    localparam logic [3:0] OP_WSGL = 4'h9;
    localparam logic [3:0] OP_RBUF = 4'hA;
    localparam logic [3:0] OP_RSGL = 4'hB;
    localparam logic [3:0] OP_WCM0 = 4'hC;
    localparam logic [3:0] OP_WCM1 = 4'hD;
    localparam logic [3:0] OP_WRD  = 4'hE;
    localparam logic [3:0] OP_STOP = 4'hF;

endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode import nand_seq_pkg::*; #(
    parameter int CNT_W = 12,
    parameter int BLK_W = 24,
    parameter int COL_W = 11,
    parameter int PG_W  = 6
) (
    input  logic [3:0]       op,
    input  logic [1:0]       idx_lo,
    input  logic             large_page,
    input  logic [1:0]       row_bytes_sel,
    input  logic [31:0]      cmd_word,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [COL_W-1:0] col_idx,
    input  logic [PG_W-1:0]  page_idx,
    input  logic [7:0]       user_addr,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             wide_single,
    input  logic [15:0]      single_wdata,
    input  logic [7:0]       buf_byte,
    output logic [CNT_W:0]   nbytes,
    output logic             is_cmd,
    output logic             is_addr,
    output logic             is_rd,
    output logic             to_buf,
    output logic             waits,
    output logic             ends,
    output logic [7:0]       tx_byte
);

    localparam int ROW_W = 32;

    logic [ROW_W-1:0] row_large;
    logic [ROW_W-1:0] row_small;
    logic [ROW_W-1:0] row_sel;
    logic [1:0]       cmd_pos;
    logic [CNT_W:0]   one_or_two;
    logic [15:0]      col_ext;

    always_comb begin
        row_large  = (ROW_W'(blk_addr) << PG_W) | ROW_W'(page_idx);
        row_small  = (ROW_W'(blk_addr) << (PG_W - 1)) | ROW_W'(page_idx[PG_W-2:0]);
        row_sel    = large_page ? row_large : row_small;
        cmd_pos    = 2'd3 - op[1:0];
        one_or_two = wide_single ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
        col_ext    = 16'(col_idx);

        nbytes  = '0;
        is_cmd  = 1'b0;
        is_addr = 1'b0;
        is_rd   = 1'b0;
        to_buf  = 1'b0;
        waits   = 1'b0;
        ends    = 1'b0;
        tx_byte = 8'h00;

        unique case (op)
            OP_END, OP_STOP: ends = 1'b1;
            OP_COL: begin
                is_addr = 1'b1;
                nbytes  = large_page ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
                tx_byte = idx_lo[0] ? col_ext[15:8] : col_ext[7:0];
            end
            OP_ROW: begin
                is_addr = 1'b1;
                nbytes  = (row_bytes_sel == 2'd0) ? (CNT_W+1)'(2) :
                          (row_bytes_sel == 2'd1) ? (CNT_W+1)'(3) : (CNT_W+1)'(4);
                tx_byte = row_sel[8*idx_lo +: 8];
            end
            OP_USR: begin
                is_addr = 1'b1;
                nbytes  = (CNT_W+1)'(1);
                tx_byte = user_addr;
            end
            OP_CM0, OP_CM1, OP_CM2, OP_CM3, OP_WCM0, OP_WCM1: begin
                is_cmd  = 1'b1;
                waits   = op[3];
                nbytes  = (CNT_W+1)'(1);
                tx_byte = cmd_word[8*cmd_pos +: 8];
            end
            OP_WBUF: begin
                nbytes  = (CNT_W+1)'(byte_cnt);
                tx_byte = buf_byte;
            end
            OP_WSGL: begin
                nbytes  = one_or_two;
                tx_byte = idx_lo[0] ? single_wdata[15:8] : single_wdata[7:0];
            end
            OP_RBUF, OP_WRD: begin
                is_rd  = 1'b1;
                to_buf = 1'b1;
                waits  = (op == OP_WRD);
                nbytes = (CNT_W+1)'(byte_cnt);
            end
            OP_RSGL: begin
                is_rd  = 1'b1;
                nbytes = one_or_two;
            end
            default: ends = 1'b1;
        endcase
    end

endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
    parameter int FIELD_W = 4,
    parameter int SHIFT   = 5,
    localparam int TW     = (1 << FIELD_W) + SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [FIELD_W-1:0] sel,
    output logic               expired
);

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] lim_m1;

    always_comb begin
        lim_m1  = (TW'(1) << (int'(sel) + SHIFT)) - TW'(1);
        expired = en && (cnt_q == lim_m1);
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/nand_buf.sv
module nand_buf #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/nand_seq.sv
module nand_seq import nand_seq_pkg::*; #(
    parameter int NOPS      = 8,
    parameter int CNT_W     = 12,
    parameter int BLK_W     = 24,
    parameter int COL_W     = 11,
    parameter int PG_W      = 6,
    parameter int TMO_W     = 4,
    parameter int TMO_SHIFT = 5,
    parameter int BUF_DEPTH = 16,
    localparam int OP_W     = 4,
    localparam int IW       = NOPS * OP_W,
    localparam int SLOT_W   = $clog2(NOPS),
    localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IW-1:0]     instr,
    input  logic [31:0]       cmd_word,
    input  logic [BLK_W-1:0]  blk_addr,
    input  logic [COL_W-1:0]  col_idx,
    input  logic [PG_W-1:0]   page_idx,
    input  logic              large_page,
    input  logic [1:0]        row_bytes_sel,
    input  logic [7:0]        user_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              wide_single,
    input  logic [15:0]       single_wdata,
    output logic [15:0]       single_rdata,
    input  logic [TMO_W-1:0]  wait_sel,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_waddr,
    input  logic [7:0]        buf_wdata,
    input  logic [BUF_AW-1:0] buf_raddr,
    output logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              cmd_done,
    output logic              wait_tmo,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_o,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_i,
    input  logic              nf_rdy
);

    typedef struct packed {
        seq_st_e           st;
        logic [SLOT_W-1:0] slot;
        logic [OP_W-1:0]   op;
        logic [CNT_W:0]    idx;
        logic              ph;
        logic              cle;
        logic              ale;
        logic              we_n;
        logic              re_n;
        logic              oe;
        logic [7:0]        dq;
        logic [15:0]       rdat;
        logic              done;
        logic              tmo;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: S_IDLE, slot: '0, op: '0, idx: '0, ph: 1'b0,
        cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1, oe: 1'b0,
        dq: '0, rdat: '0, done: 1'b0, tmo: 1'b0
    };

    seq_t s_d, s_q;

    logic [OP_W-1:0]   cur_op;
    logic [OP_W-1:0]   dec_op;
    logic [CNT_W:0]    nbytes;
    logic              is_cmd, is_addr, is_rd, to_buf, waits, ends;
    logic [7:0]        tx_byte;
    logic [7:0]        buf_seq_byte;
    logic              tmr_clr, tmr_en, tmr_exp;
    logic              seq_bwe;
    logic              adv;
    logic              mem_we;
    logic [BUF_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    assign cur_op = instr[OP_W*(NOPS-1-int'(s_q.slot)) +: OP_W];
    assign dec_op = (s_q.st == S_FETCH) ? cur_op : s_q.op;

    nand_op_decode #(
        .CNT_W(CNT_W), .BLK_W(BLK_W), .COL_W(COL_W), .PG_W(PG_W)
    ) u_dec (
        .op           (dec_op),
        .idx_lo       (s_q.idx[1:0]),
        .large_page   (large_page),
        .row_bytes_sel(row_bytes_sel),
        .cmd_word     (cmd_word),
        .blk_addr     (blk_addr),
        .col_idx      (col_idx),
        .page_idx     (page_idx),
        .user_addr    (user_addr),
        .byte_cnt     (byte_cnt),
        .wide_single  (wide_single),
        .single_wdata (single_wdata),
        .buf_byte     (buf_seq_byte),
        .nbytes       (nbytes),
        .is_cmd       (is_cmd),
        .is_addr      (is_addr),
        .is_rd        (is_rd),
        .to_buf       (to_buf),
        .waits        (waits),
        .ends         (ends),
        .tx_byte      (tx_byte)
    );

    nand_wait_timer #(
        .FIELD_W(TMO_W), .SHIFT(TMO_SHIFT)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .en     (tmr_en),
        .sel    (wait_sel),
        .expired(tmr_exp)
    );

    // sequencer captures have priority over host writes
    assign mem_we    = seq_bwe | buf_we;
    assign mem_waddr = seq_bwe ? s_q.idx[BUF_AW-1:0] : buf_waddr;
    assign mem_wdata = seq_bwe ? nf_dq_i : buf_wdata;

    nand_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr_a(buf_raddr),
        .rdata_a(buf_rdata),
        .raddr_b(s_q.idx[BUF_AW-1:0]),
        .rdata_b(buf_seq_byte)
    );

    always_comb begin
        s_d     = s_q;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        seq_bwe = 1'b0;
        adv     = 1'b0;

        unique case (s_q.st)
            S_IDLE: begin
                s_d.cle = 1'b0;
                s_d.ale = 1'b0;
                s_d.oe  = 1'b0;
                if (start) begin
                    s_d.st   = S_FETCH;
                    s_d.slot = '0;
                    s_d.done = 1'b0;
                    s_d.tmo  = 1'b0;
                end
            end
            S_FETCH: begin
                s_d.cle = 1'b0;
                s_d.ale = 1'b0;
                s_d.oe  = 1'b0;
                tmr_clr = 1'b1;
                s_d.op  = cur_op;
                s_d.idx = '0;
                s_d.ph  = 1'b0;
                if (ends) begin
                    s_d.st   = S_IDLE;
                    s_d.done = 1'b1;
                end else if (waits) begin
                    s_d.st = S_WAIT;
                end else if (nbytes == '0) begin
                    adv = 1'b1;
                end else begin
                    s_d.st = S_XFER;
                end
            end
            S_WAIT: begin
                s_d.oe = 1'b0;
                tmr_en = !nf_rdy;
                if (nf_rdy) begin
                    if (nbytes == '0) adv = 1'b1;
                    else              s_d.st = S_XFER;
                end else if (tmr_exp) begin
                    s_d.st  = S_IDLE;
                    s_d.tmo = 1'b1;
                end
            end
            S_XFER: begin
                if (!s_q.ph) begin
                    s_d.we_n = is_rd;
                    s_d.re_n = !is_rd;
                    s_d.cle  = is_cmd;
                    s_d.ale  = is_addr;
                    s_d.oe   = !is_rd;
                    s_d.dq   = is_rd ? s_q.dq : tx_byte;
                    s_d.ph   = 1'b1;
                end else begin
                    s_d.we_n = 1'b1;
                    s_d.re_n = 1'b1;
                    if (is_rd) begin
                        if (to_buf)          seq_bwe = 1'b1;
                        else if (s_q.idx[0]) s_d.rdat[15:8] = nf_dq_i;
                        else                 s_d.rdat[7:0]  = nf_dq_i;
                    end
                    if (s_q.idx == nbytes - (CNT_W+1)'(1)) begin
                        adv = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + (CNT_W+1)'(1);
                        s_d.ph  = 1'b0;
                    end
                end
            end
            default: s_d = SEQ_RST;
        endcase

        if (adv) begin
            if (s_q.slot == SLOT_W'(NOPS - 1)) begin
                s_d.st   = S_IDLE;
                s_d.done = 1'b1;
            end else begin
                s_d.st   = S_FETCH;
                s_d.slot = s_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign busy         = (s_q.st != S_IDLE);
    assign cmd_done     = s_q.done;
    assign wait_tmo     = s_q.tmo;
    assign nf_cle       = s_q.cle;
    assign nf_ale       = s_q.ale;
    assign nf_we_n      = s_q.we_n;
    assign nf_re_n      = s_q.re_n;
    assign nf_dq_o      = s_q.dq;
    assign nf_dq_oe     = s_q.oe;
    assign single_rdata = s_q.rdat;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic cmd_done,
    input logic wait_tmo,
    input logic nf_cle,
    input logic nf_ale,
    input logic nf_we_n,
    input logic nf_re_n,
    input logic nf_dq_oe,
    input logic nf_rdy
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nf_we_n && nf_re_n));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    p_we_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_we_n) |=> $rose(nf_we_n));

    p_re_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_re_n) |=> $rose(nf_re_n));

    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cmd_done || wait_tmo));

    p_read_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);

    p_tmo_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_tmo) |-> $past(!nf_rdy));

    p_flags_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && wait_tmo));

    p_start_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !cmd_done && !wait_tmo));

endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .cmd_done(cmd_done),
    .wait_tmo(wait_tmo),
    .nf_cle  (nf_cle),
    .nf_ale  (nf_ale),
    .nf_we_n (nf_we_n),
    .nf_re_n (nf_re_n),
    .nf_dq_oe(nf_dq_oe),
    .nf_rdy  (nf_rdy)
);

// File: tb/sim_nand_seq.sv
`timescale 1ns/1ps
module sim_nand_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] cmd_word = 32'hA1B2C3D4;
    logic [23:0] blk_addr = 24'h0ABCDE;
    logic [10:0] col_idx = 11'h5A3;
    logic [5:0]  page_idx = 6'h2B;
    logic        large_page = 1'b1;
    logic [1:0]  row_bytes_sel = 2'd1;
    logic [7:0]  user_addr = 8'h5E;
    logic [11:0] byte_cnt = '0;
    logic        wide_single = 1'b0;
    logic [15:0] single_wdata = 16'hBEEF;
    logic [15:0] single_rdata;
    logic [3:0]  wait_sel = 4'd0;
    logic        buf_we = 1'b0;
    logic [3:0]  buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;
    logic [3:0]  buf_raddr = '0;
    logic [7:0]  buf_rdata;
    logic        busy, cmd_done, wait_tmo;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o;
    logic [7:0]  nf_dq_i;
    logic        nf_rdy = 1'b1;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    nand_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .cmd_word(cmd_word), .blk_addr(blk_addr), .col_idx(col_idx),
        .page_idx(page_idx), .large_page(large_page),
        .row_bytes_sel(row_bytes_sel), .user_addr(user_addr),
        .byte_cnt(byte_cnt), .wide_single(wide_single),
        .single_wdata(single_wdata), .single_rdata(single_rdata),
        .wait_sel(wait_sel), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .busy(busy), .cmd_done(cmd_done), .wait_tmo(wait_tmo),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
        .nf_dq_i(nf_dq_i), .nf_rdy(nf_rdy)
    );

    // flash pin model: log every write strobe, feed a counting pattern on reads
    logic [10:0] wlog [256];
    int wcnt = 0;
    int rcnt = 0;

    always @(posedge nf_we_n) begin
        wlog[wcnt % 256] = {nf_cle, nf_ale, nf_dq_oe, nf_dq_o};
        wcnt++;
    end

    always @(posedge nf_re_n) rcnt++;

    assign nf_dq_i = 8'h30 + 8'(rcnt);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_is(input int n, input bit cle, input bit ale,
                            input logic [7:0] dq, input string req);
        logic [10:0] e;
        e = {cle, ale, 1'b1, dq};
        chk(wlog[n % 256] == e, req, int'(wlog[n % 256]), int'(e));
    endtask

    task automatic run(input logic [31:0] prog);
        int n;
        instr = prog;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic load_buf();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_waddr = 4'(i); buf_wdata = 8'h60 + 8'(i);
        end
        @(negedge clk) buf_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !cmd_done && !wait_tmo, "R1 flags", {busy, cmd_done, wait_tmo}, 0);
        chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe, "R1 pins",
            {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 5'b11000);
    endtask

    task automatic t_cmd_addr_large();
        int b;
        b = wcnt;
        large_page = 1'b1; row_bytes_sel = 2'd1;
        run(32'h4125_0000);
        chk(wcnt - b == 7, "R6 pulse count", wcnt - b, 7);
        pulse_is(b + 0, 1, 0, 8'hA1, "R3 cmd0");
        pulse_is(b + 1, 0, 1, 8'hA3, "R4 col lo");
        pulse_is(b + 2, 0, 1, 8'h05, "R4 col hi");
        pulse_is(b + 3, 0, 1, 8'hAB, "R5 row0");
        pulse_is(b + 4, 0, 1, 8'h37, "R5 row1");
        pulse_is(b + 5, 0, 1, 8'hAF, "R5 row2");
        pulse_is(b + 6, 1, 0, 8'hB2, "R2 order cmd1 last");
        chk(cmd_done && !wait_tmo, "R6 done", {cmd_done, wait_tmo}, 2'b10);
    endtask

    task automatic t_small_page();
        int b;
        b = wcnt;
        large_page = 1'b0; row_bytes_sel = 2'd2;
        run(32'h12F4_0000);
        chk(wcnt - b == 5, "R6 stop opcode 15", wcnt - b, 5);
        pulse_is(b + 0, 0, 1, 8'hA3, "R4 small col");
        pulse_is(b + 1, 0, 1, 8'hCB, "R5 small row0");
        pulse_is(b + 2, 0, 1, 8'h9B, "R5 small row1");
        pulse_is(b + 3, 0, 1, 8'h57, "R5 small row2");
        pulse_is(b + 4, 0, 1, 8'h01, "R5 small row3");
        b = wcnt;
        row_bytes_sel = 2'd0;
        run(32'h2000_0000);
        chk(wcnt - b == 2, "R5 two row bytes", wcnt - b, 2);
        pulse_is(b + 1, 0, 1, 8'h9B, "R5 row sel0");
        large_page = 1'b1; row_bytes_sel = 2'd1;
    endtask

    task automatic t_user_cmds();
        int b;
        b = wcnt;
        run(32'h3670_0000);
        chk(wcnt - b == 3, "R5 user count", wcnt - b, 3);
        pulse_is(b + 0, 0, 1, 8'h5E, "R5 user byte");
        pulse_is(b + 1, 1, 0, 8'hC3, "R3 cmd2");
        pulse_is(b + 2, 1, 0, 8'hD4, "R3 cmd3");
    endtask

    task automatic t_full_eight();
        int b;
        b = wcnt;
        run(32'h4444_4444);
        chk(wcnt - b == 8, "R2 all eight slots", wcnt - b, 8);
        pulse_is(b + 7, 1, 0, 8'hA1, "R2 last slot");
        chk(cmd_done, "R2 done after slot 7", cmd_done, 1);
    endtask

    task automatic t_buf_write();
        int b;
        load_buf();
        b = wcnt;
        byte_cnt = 12'd5;
        run(32'h8500_0000);
        chk(wcnt - b == 6, "R7 count", wcnt - b, 6);
        for (int i = 0; i < 5; i++) pulse_is(b + i, 0, 0, 8'h60 + 8'(i), "R7 data");
        pulse_is(b + 5, 1, 0, 8'hB2, "R7 then cmd1");
        b = wcnt;
        byte_cnt = 12'd18;
        run(32'h8000_0000);
        chk(wcnt - b == 18, "R7 long count", wcnt - b, 18);
        pulse_is(b + 16, 0, 0, 8'h60, "R7 wrap 16");
        pulse_is(b + 17, 0, 0, 8'h61, "R7 wrap 17");
        b = wcnt;
        byte_cnt = 12'd0;
        run(32'h8400_0000);
        chk(wcnt - b == 1, "R7 zero count", wcnt - b, 1);
        pulse_is(b, 1, 0, 8'hA1, "R7 zero then cmd0");
    endtask

    task automatic t_single_write();
        int b;
        b = wcnt;
        wide_single = 1'b0;
        run(32'h9000_0000);
        chk(wcnt - b == 1, "R8 narrow count", wcnt - b, 1);
        pulse_is(b, 0, 0, 8'hEF, "R8 narrow");
        b = wcnt;
        wide_single = 1'b1;
        run(32'h9000_0000);
        chk(wcnt - b == 2, "R8 wide count", wcnt - b, 2);
        pulse_is(b + 0, 0, 0, 8'hEF, "R8 wide lo");
        pulse_is(b + 1, 0, 0, 8'hBE, "R8 wide hi");
    endtask

    task automatic t_buf_read();
        int r, b;
        load_buf();
        r = rcnt; b = wcnt;
        byte_cnt = 12'd4;
        run(32'hA000_0000);
        chk(rcnt - r == 4, "R9 read count", rcnt - r, 4);
        chk(wcnt == b, "R9 no write strobe", wcnt - b, 0);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] e;
            e = (i < 4) ? 8'h30 + 8'(r + i) : 8'h64;
            @(negedge clk) buf_raddr = 4'(i);
            #1 chk(buf_rdata == e, "R9 buffer", buf_rdata, e);
        end
    endtask

    task automatic t_single_read();
        int r;
        logic [7:0] lo, hi;
        r = rcnt;
        wide_single = 1'b1;
        run(32'hB000_0000);
        lo = 8'h30 + 8'(r); hi = 8'h31 + 8'(r);
        chk(single_rdata == {hi, lo}, "R10 wide read", single_rdata, {hi, lo});
        r = rcnt;
        wide_single = 1'b0;
        run(32'hB000_0000);
        lo = 8'h30 + 8'(r);
        chk(single_rdata == {hi, lo}, "R10 narrow keeps upper", single_rdata, {hi, lo});
    endtask

    task automatic t_wait_ready();
        int b, r;
        b = wcnt;
        nf_rdy = 1'b0;
        instr = 32'hD000_0000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(busy && wcnt == b, "R11 holds while not ready", wcnt - b, 0);
        nf_rdy = 1'b1;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        chk(wcnt - b == 1, "R11 cmd after ready", wcnt - b, 1);
        pulse_is(b, 1, 0, 8'hB2, "R11 cmd1 byte");
        chk(cmd_done && !wait_tmo, "R11 done", {cmd_done, wait_tmo}, 2'b10);
        r = rcnt;
        byte_cnt = 12'd2;
        run(32'hE000_0000);
        chk(rcnt - r == 2, "R11 wait read count", rcnt - r, 2);
        @(negedge clk) buf_raddr = 4'd1;
        #1 chk(buf_rdata == 8'h31 + 8'(r), "R11 wait read data", buf_rdata, 8'h31 + 8'(r));
    endtask

    task automatic t_timeout();
        int b, n;
        b = wcnt;
        nf_rdy = 1'b0;
        wait_sel = 4'd0;
        instr = 32'hC400_0000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == 33, "R12 busy length", n, 33);
        chk(wait_tmo && !cmd_done, "R12 timeout flag", {cmd_done, wait_tmo}, 2'b01);
        chk(wcnt == b, "R12 abort", wcnt - b, 0);
        nf_rdy = 1'b1;
        run(32'h4000_0000);
        chk(cmd_done && !wait_tmo, "R13 start clears", {cmd_done, wait_tmo}, 2'b10);
    endtask

    task automatic t_start_busy();
        int b;
        b = wcnt;
        nf_rdy = 1'b0;
        instr = 32'hC000_0000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        instr = 32'h4000_0000;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        nf_rdy = 1'b1;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        chk(wcnt - b == 1, "R13 start while busy", wcnt - b, 1);
        pulse_is(b, 1, 0, 8'hA1, "R13 original program");
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_addr_large();
        t_small_page();
        t_user_cmds();
        t_full_eight();
        t_buf_write();
        t_single_write();
        t_buf_read();
        t_single_read();
        t_wait_ready();
        t_timeout();
        t_start_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule